// File: doc/BRIEF.md
# Fault Status and Escalation Unit

This unit sits beside the exception logic of a processor core. The detection logic elsewhere reports three kinds of configurable fault: a memory-protection fault, a bus fault and a usage fault. For every event, the unit decides in the same cycle whether that fault's own handler can run. If it cannot, the unit escalates the fault to a hard fault. It also records the causes in sticky status bits that software clears by writing ones. Two more event inputs, a debug event and a failed vector fetch, raise a hard fault directly.

For memory-protection and bus faults, the detection logic can also supply a faulting address. The unit keeps that address together with a valid flag. Only the first address is stored, and it stays until software clears the flag. A small word-indexed register port exposes the hard-fault status, the combined fault status word and the two address registers. Reads are combinational. A write takes effect at the next clock edge.

Top module: `fault_status_unit`

## Requirements
- R1: After a synchronous active-low reset, all four registers read zero and every decision output is low while no event is present.
- R2: Hard-fault status word (index 0) layout: bit 31 records a debug event, bit 30 records a forced escalation and bit 1 records a failed vector fetch. All other bits read zero. A debug or vector event raises `take_hard` in the same cycle and sets its bit at the next edge.
- R3: Combined fault status word (index 1) layout:
  - Memory-fault causes sit in bits 6:0, with the memory-address valid flag in bit 7.
  - Bus-fault causes sit in bits 14:8, where bit 9 (bus cause input bit 1) is the precise data bus error, with the bus-address valid flag in bit 15.
  - Usage-fault causes sit in bits 31:16.
  - An event ORs its cause vector into its field at the next edge.
- R4: A configurable fault is taken at its own level (`take_mem`, `take_bus`, `take_usage`) in the same cycle only when its enable is 1 and its priority value is numerically below `cur_pri`. An equal value does not preempt.
- R5: In every other case the event raises `take_hard`, sets bit 30 of the hard-fault word at the next edge, and still records its cause bits in the combined word.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R7: A fault event that sets a bit in the same cycle as a write clearing that bit wins: the bit ends up set.
- R8: An event with its address-ok input high, while the matching valid flag is clear, stores the address and sets the flag.
- R9: While a valid flag is set, its address register keeps the first stored address. If a new event with an address arrives in the same cycle as a write clearing that flag, the new address is stored and the flag stays set.
- R10: Writes to the two address registers (indices 2 and 3) have no effect.
- R11: `rd_data` returns the word selected by `reg_sel`: index 0 hard-fault status, 1 combined status, 2 memory fault address, 3 bus fault address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_evt | input | 1 | Memory-protection fault event |
| mem_cause | input | 7 | Memory-fault cause bits |
| mem_addr_ok | input | 1 | Memory-fault address is meaningful |
| mem_addr | input | 32 | Memory-fault address |
| bus_evt | input | 1 | Bus fault event |
| bus_cause | input | 7 | Bus-fault cause bits |
| bus_addr_ok | input | 1 | Bus-fault address is meaningful |
| bus_addr | input | 32 | Bus-fault address |
| usage_evt | input | 1 | Usage fault event |
| usage_cause | input | 16 | Usage-fault cause bits |
| dbg_evt | input | 1 | Debug event that raises a hard fault |
| vec_evt | input | 1 | Failed vector fetch |
| mem_en | input | 1 | Memory-fault handler enable |
| bus_en | input | 1 | Bus-fault handler enable |
| usage_en | input | 1 | Usage-fault handler enable |
| mem_pri | input | PRI_W | Memory-fault priority (lower value is more urgent) |
| bus_pri | input | PRI_W | Bus-fault priority |
| usage_pri | input | PRI_W | Usage-fault priority |
| cur_pri | input | PRI_W | Current execution priority |
| reg_sel | input | 2 | Register word index |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data (ones clear status bits) |
| rd_data | output | 32 | Selected register word |
| take_mem | output | 1 | Memory fault handled at its own level |
| take_bus | output | 1 | Bus fault handled at its own level |
| take_usage | output | 1 | Usage fault handled at its own level |
| take_hard | output | 1 | Hard fault raised this cycle |

## Verification
The assertions assume the following about the inputs:
- The cause vector of an event is nonzero whenever it matters.
- `reg_sel` and `wr_en` are always driven to known values.
- The address inputs are stable during the cycle that an event presents them.

The stimulus meets these assumptions in two ways. It drives every input from bench variables, changing them only at the falling edge. It draws cause vectors and addresses from a seeded generator, with event, enable and write probabilities chosen so that valid flags are often set and often cleared. Directed cases then place set-versus-clear collisions, equal priorities and address-register writes at known cycles.

// File: rtl/fsu_pkg.sv
// Package: shared constants and register index type for the fault status unit.
// Assumes a 32-bit register port and fixed field positions in the status words.
package fsu_pkg;
    localparam int DATA_W     = 32;
    localparam int MEM_CW     = 7;
    localparam int BUS_CW     = 7;
    localparam int USE_CW     = 16;
    localparam int NUM_KINDS  = 3;
    localparam int HW_DBG     = 31;
    localparam int HW_FORCED  = 30;
    localparam int HW_VEC     = 1;
    localparam int CW_MEM_VLD = 7;
    localparam int CW_BUS_VLD = 15;

    typedef enum logic [1:0] {
        SEL_HARD  = 2'd0,
        SEL_COMB  = 2'd1,
        SEL_MADDR = 2'd2,
        SEL_BADDR = 2'd3
    } fsu_sel_e;
endpackage

// File: rtl/fsu_sticky.sv
// Module: bank of sticky status bits, set by hardware and cleared by writing ones.
// Assumes set and clr are single-cycle strobes; set wins over clr on the same bit.
module fsu_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    // Purpose: hold bits, clear on write-one, give set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/fsu_addr_latch.sv
// Module: faulting address holder that keeps the first address while its flag is set.
// Assumes the flag itself lives in a sticky bank; this block only sees its state.
module fsu_addr_latch #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_ok,
    input  logic          valid_q,
    input  logic          valid_clr,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] q
);
    logic capture;

    // Purpose: capture only when the flag is free or being freed this cycle.
    always_comb capture = evt_ok && (!valid_q || valid_clr);

    // Purpose: address register.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (capture) q <= addr_in;
    end
endmodule

// File: rtl/fsu_escalate.sv
// Module: decides whether one configurable fault runs at its own level or escalates.
// Assumes lower priority values are more urgent; an equal value does not preempt.
module fsu_escalate #(
    parameter int PRI_W = 3
) (
    input  logic             evt,
    input  logic             en,
    input  logic [PRI_W-1:0] pri,
    input  logic [PRI_W-1:0] cur_pri,
    output logic             take_local,
    output logic             escalate
);
    // Purpose: enable and priority comparison.
    always_comb begin
        take_local = evt && en && (pri < cur_pri);
        escalate   = evt && !take_local;
    end
endmodule

// File: rtl/fault_status_unit.sv
// Module: fault status and escalation unit top.
// Records configurable and hard fault causes in write-one-to-clear registers,
// captures fault addresses and makes the same-cycle escalation decision.
// Assumes one register access per cycle with combinational reads.
module fault_status_unit
    import fsu_pkg::*;
#(
    parameter int PRI_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_evt,
    input  logic [MEM_CW-1:0] mem_cause,
    input  logic              mem_addr_ok,
    input  logic [DATA_W-1:0] mem_addr,
    input  logic              bus_evt,
    input  logic [BUS_CW-1:0] bus_cause,
    input  logic              bus_addr_ok,
    input  logic [DATA_W-1:0] bus_addr,
    input  logic              usage_evt,
    input  logic [USE_CW-1:0] usage_cause,
    input  logic              dbg_evt,
    input  logic              vec_evt,
    input  logic              mem_en,
    input  logic              bus_en,
    input  logic              usage_en,
    input  logic [PRI_W-1:0]  mem_pri,
    input  logic [PRI_W-1:0]  bus_pri,
    input  logic [PRI_W-1:0]  usage_pri,
    input  logic [PRI_W-1:0]  cur_pri,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              take_mem,
    output logic              take_bus,
    output logic              take_usage,
    output logic              take_hard
);
    localparam int HBITS = 3;

    logic [NUM_KINDS-1:0] evt_v, en_v, take_v, esc_v;
    logic [PRI_W-1:0]     pri_v [NUM_KINDS];

    // Purpose: gather per-kind inputs into arrays for the generate loop.
    always_comb begin
        evt_v    = {usage_evt, bus_evt, mem_evt};
        en_v     = {usage_en, bus_en, mem_en};
        pri_v[0] = mem_pri;
        pri_v[1] = bus_pri;
        pri_v[2] = usage_pri;
    end

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_dec
        fsu_escalate #(.PRI_W(PRI_W)) u_dec (
            .evt       (evt_v[k]),
            .en        (en_v[k]),
            .pri       (pri_v[k]),
            .cur_pri   (cur_pri),
            .take_local(take_v[k]),
            .escalate  (esc_v[k])
        );
    end

    // Purpose: decision outputs.
    always_comb begin
        take_mem   = take_v[0];
        take_bus   = take_v[1];
        take_usage = take_v[2];
        take_hard  = (|esc_v) || dbg_evt || vec_evt;
    end

    // Write decode into clear vectors.
    logic              wr_hard, wr_comb;
    logic [DATA_W-1:0] comb_set, comb_clr, comb_q;
    logic [HBITS-1:0]  hard_set, hard_clr, hard_q;

    // Purpose: decode register writes and build set vectors.
    always_comb begin
        wr_hard  = wr_en && (fsu_sel_e'(reg_sel) == SEL_HARD);
        wr_comb  = wr_en && (fsu_sel_e'(reg_sel) == SEL_COMB);
        comb_clr = wr_comb ? wr_data : '0;
        hard_clr = wr_hard ? {wr_data[HW_DBG], wr_data[HW_FORCED], wr_data[HW_VEC]}
                           : '0;
        comb_set = {usage_evt ? usage_cause : '0,
                    bus_evt && bus_addr_ok,
                    bus_evt ? bus_cause : '0,
                    mem_evt && mem_addr_ok,
                    mem_evt ? mem_cause : '0};
        hard_set = {dbg_evt, |esc_v, vec_evt};
    end

    fsu_sticky #(.W(DATA_W)) u_comb (
        .clk(clk), .rst_n(rst_n), .set(comb_set), .clr(comb_clr), .q(comb_q)
    );

    fsu_sticky #(.W(HBITS)) u_hard (
        .clk(clk), .rst_n(rst_n), .set(hard_set), .clr(hard_clr), .q(hard_q)
    );

    logic [DATA_W-1:0] maddr_q, baddr_q;

    fsu_addr_latch #(.AW(DATA_W)) u_maddr (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_ok   (mem_evt && mem_addr_ok),
        .valid_q  (comb_q[CW_MEM_VLD]),
        .valid_clr(comb_clr[CW_MEM_VLD]),
        .addr_in  (mem_addr),
        .q        (maddr_q)
    );

    fsu_addr_latch #(.AW(DATA_W)) u_baddr (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_ok   (bus_evt && bus_addr_ok),
        .valid_q  (comb_q[CW_BUS_VLD]),
        .valid_clr(comb_clr[CW_BUS_VLD]),
        .addr_in  (bus_addr),
        .q        (baddr_q)
    );

    logic [DATA_W-1:0] hard_word;

    // Purpose: place hard-fault bits into their word positions and select a read.
    always_comb begin
        hard_word            = '0;
        hard_word[HW_DBG]    = hard_q[2];
        hard_word[HW_FORCED] = hard_q[1];
        hard_word[HW_VEC]    = hard_q[0];
        unique case (fsu_sel_e'(reg_sel))
            SEL_HARD:  rd_data = hard_word;
            SEL_COMB:  rd_data = comb_q;
            SEL_MADDR: rd_data = maddr_q;
            default:   rd_data = baddr_q;
        endcase
    end
endmodule

// File: rtl/fsu_checker.sv
// Module: property checker for the fault status unit, attached by bind.
// Assumes it sees the top's ports plus its stored register words.
module fsu_checker #(
    parameter int PRI_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_evt,
    input logic             mem_en,
    input logic [PRI_W-1:0] mem_pri,
    input logic [PRI_W-1:0] cur_pri,
    input logic             bus_evt,
    input logic             bus_addr_ok,
    input logic             dbg_evt,
    input logic             vec_evt,
    input logic [1:0]       reg_sel,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic [31:0]      rd_data,
    input logic             take_mem,
    input logic             take_hard,
    input logic [2:0]       hard_q,
    input logic [31:0]      comb_q,
    input logic [31:0]      baddr_q
);
    logic clr_comb;
    always_comb clr_comb = wr_en && reg_sel == 2'd1;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd0) |-> ((rd_data & 32'h3FFF_FFFD) == 32'h0));

    a_r2_direct_hard: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_evt || vec_evt) |-> take_hard);

    a_r4_local_rule: assert property (@(posedge clk) disable iff (!rst_n)
        take_mem |-> (mem_evt && mem_en && mem_pri < cur_pri && !$isunknown(cur_pri)));

    a_r5_forced_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_evt && (!mem_en || !(mem_pri < cur_pri))) |=> hard_q[1]);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_evt && bus_addr_ok) |=> comb_q[15]);

    a_r6_sticky_bit9: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_q[9] && !(clr_comb && wr_data[9])) |=> comb_q[9]);

    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_q[15] && !(clr_comb && wr_data[15])) |=> $stable(baddr_q));
endmodule

bind fault_status_unit fsu_checker #(.PRI_W(PRI_W)) u_fsu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_evt    (mem_evt),
    .mem_en     (mem_en),
    .mem_pri    (mem_pri),
    .cur_pri    (cur_pri),
    .bus_evt    (bus_evt),
    .bus_addr_ok(bus_addr_ok),
    .dbg_evt    (dbg_evt),
    .vec_evt    (vec_evt),
    .reg_sel    (reg_sel),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .take_mem   (take_mem),
    .take_hard  (take_hard),
    .hard_q     (hard_q),
    .comb_q     (comb_q),
    .baddr_q    (baddr_q)
);

// File: tb/tb_fault_status_unit.sv
// Bench: seeded random plus directed cases, checked against a model built from the requirements.
module tb_fault_status_unit;
    localparam int PW = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_evt, mem_addr_ok, bus_evt, bus_addr_ok, usage_evt, dbg_evt, vec_evt;
    logic [6:0]  mem_cause, bus_cause;
    logic [15:0] usage_cause;
    logic [31:0] mem_addr, bus_addr, wr_data, rd_data;
    logic        mem_en, bus_en, usage_en, wr_en;
    logic [PW-1:0] mem_pri, bus_pri, usage_pri, cur_pri;
    logic [1:0]  reg_sel;
    logic        take_mem, take_bus, take_usage, take_hard;

    int checks = 0;
    int errors = 0;

    // Model state.
    logic        m_dbg, m_forced, m_vec;
    logic [31:0] m_comb, m_maddr, m_baddr;

    fault_status_unit #(.PRI_W(PW)) dut (
        .clk(clk), .rst_n(rst_n),
        .mem_evt(mem_evt), .mem_cause(mem_cause), .mem_addr_ok(mem_addr_ok), .mem_addr(mem_addr),
        .bus_evt(bus_evt), .bus_cause(bus_cause), .bus_addr_ok(bus_addr_ok), .bus_addr(bus_addr),
        .usage_evt(usage_evt), .usage_cause(usage_cause),
        .dbg_evt(dbg_evt), .vec_evt(vec_evt),
        .mem_en(mem_en), .bus_en(bus_en), .usage_en(usage_en),
        .mem_pri(mem_pri), .bus_pri(bus_pri), .usage_pri(usage_pri), .cur_pri(cur_pri),
        .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .take_mem(take_mem), .take_bus(take_bus), .take_usage(take_usage), .take_hard(take_hard)
    );

    always #2 clk = ~clk;

    function automatic logic local_ok(logic evt, logic en, logic [PW-1:0] p, logic [PW-1:0] c);
        return evt && en && (p < c);
    endfunction

    function automatic logic [31:0] exp_read(logic [1:0] s);
        case (s)
            2'd0:    return {m_dbg, m_forced, 28'h0, m_vec, 1'b0};
            2'd1:    return m_comb;
            2'd2:    return m_maddr;
            default: return m_baddr;
        endcase
    endfunction

    task automatic check32(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        mem_evt = 0; bus_evt = 0; usage_evt = 0; dbg_evt = 0; vec_evt = 0;
        mem_addr_ok = 0; bus_addr_ok = 0; mem_cause = '0; bus_cause = '0; usage_cause = '0;
        mem_addr = '0; bus_addr = '0; mem_en = 1; bus_en = 1; usage_en = 1;
        mem_pri = 1; bus_pri = 1; usage_pri = 1; cur_pri = 3'd7;
        wr_en = 0; wr_data = '0; reg_sel = 2'd0;
    endtask

    // One cycle: inputs already driven after a falling edge; check, advance model, clock.
    task automatic step(string tag);
        logic        em, eb, eu, eh, esc;
        logic [31:0] clr, set;
        #1;
        em  = local_ok(mem_evt, mem_en, mem_pri, cur_pri);
        eb  = local_ok(bus_evt, bus_en, bus_pri, cur_pri);
        eu  = local_ok(usage_evt, usage_en, usage_pri, cur_pri);
        esc = (mem_evt && !em) || (bus_evt && !eb) || (usage_evt && !eu);
        eh  = esc || dbg_evt || vec_evt;
        check32({tag, " take"}, {28'h0, take_hard, take_usage, take_bus, take_mem},
                {28'h0, eh, eu, eb, em});
        check32({tag, " read"}, rd_data, exp_read(reg_sel));
        clr = (wr_en && reg_sel == 2'd1) ? wr_data : 32'h0;
        set = {usage_evt ? usage_cause : 16'h0, bus_evt && bus_addr_ok,
               bus_evt ? bus_cause : 7'h0, mem_evt && mem_addr_ok, mem_evt ? mem_cause : 7'h0};
        @(posedge clk);
        if (mem_evt && mem_addr_ok && (!m_comb[7] || clr[7]))   m_maddr = mem_addr;
        if (bus_evt && bus_addr_ok && (!m_comb[15] || clr[15])) m_baddr = bus_addr;
        m_comb = (m_comb & ~clr) | set;
        if (wr_en && reg_sel == 2'd0) begin
            if (wr_data[31]) m_dbg = 0;
            if (wr_data[30]) m_forced = 0;
            if (wr_data[1])  m_vec = 0;
        end
        if (dbg_evt) m_dbg = 1;
        if (esc)     m_forced = 1;
        if (vec_evt) m_vec = 1;
        @(negedge clk);
    endtask

    task automatic read_all(string tag);
        for (int s = 0; s < 4; s++) begin
            idle();
            reg_sel = 2'(s);
            step(tag);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        idle();
        rst_n = 0;
        m_dbg = 0; m_forced = 0; m_vec = 0; m_comb = '0; m_maddr = '0; m_baddr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset values, R11 read map
        read_all("R1 R11 reset");

        // R2 debug then vector event raise hard fault and set their bits
        idle(); dbg_evt = 1; step("R2 debug event");
        idle(); vec_evt = 1; step("R2 vector event");
        read_all("R2 hard word");

        // R4 local bus fault, R3 bit 9 position, R8 capture
        idle(); bus_evt = 1; bus_cause = 7'b0000010; bus_addr_ok = 1;
        bus_addr = 32'h4002_1018; bus_pri = 1; cur_pri = 2; reg_sel = 2'd1;
        step("R4 R8 bus local");
        idle(); reg_sel = 2'd1; step("R3 comb word bit9 bit15");
        // R9 second address ignored while flag set
        idle(); bus_evt = 1; bus_cause = 7'b0000001; bus_addr_ok = 1; bus_addr = 32'hDEAD_0000;
        step("R9 hold first");
        idle(); reg_sel = 2'd3; step("R9 bus addr kept");

        // R5 disabled memory fault escalates; R4 equal priority escalates
        idle(); mem_evt = 1; mem_en = 0; mem_cause = 7'h05; mem_addr_ok = 1; mem_addr = 32'h2000_0100;
        step("R5 disabled escalate");
        idle(); usage_evt = 1; usage_cause = 16'h0100; usage_pri = 3; cur_pri = 3;
        step("R4 R5 equal priority");
        read_all("R5 forced and causes");

        // R6 write zero keeps, write one clears one bit
        idle(); wr_en = 1; reg_sel = 2'd1; wr_data = 32'h0; step("R6 write zero");
        idle(); wr_en = 1; reg_sel = 2'd1; wr_data = 32'h0000_0200; step("R6 clear bit9");
        idle(); wr_en = 1; reg_sel = 2'd0; wr_data = 32'h4000_0000; step("R6 clear forced");
        read_all("R6 after clears");

        // R7 R9 clear of valid with a new address the same cycle
        idle(); wr_en = 1; reg_sel = 2'd1; wr_data = 32'h0000_8000;
        bus_evt = 1; bus_cause = 7'h01; bus_addr_ok = 1; bus_addr = 32'h1234_5678;
        step("R7 R9 set beats clear");
        read_all("R7 R9 result");

        // R10 writes to address registers ignored
        idle(); wr_en = 1; reg_sel = 2'd2; wr_data = 32'hFFFF_FFFF; step("R10 maddr write");
        idle(); wr_en = 1; reg_sel = 2'd3; wr_data = 32'hFFFF_FFFF; step("R10 baddr write");
        read_all("R10 unchanged");

        // Random mix covering R3..R9 together
        for (int i = 0; i < 3000; i++) begin
            idle();
            mem_evt     = ($urandom % 5) == 0;
            bus_evt     = ($urandom % 5) == 0;
            usage_evt   = ($urandom % 5) == 0;
            dbg_evt     = ($urandom % 23) == 0;
            vec_evt     = ($urandom % 29) == 0;
            mem_cause   = 7'($urandom);
            bus_cause   = 7'($urandom);
            usage_cause = 16'($urandom);
            mem_addr_ok = $urandom % 2;
            bus_addr_ok = $urandom % 2;
            mem_addr    = $urandom;
            bus_addr    = $urandom;
            mem_en      = ($urandom % 4) != 0;
            bus_en      = ($urandom % 4) != 0;
            usage_en    = ($urandom % 4) != 0;
            mem_pri     = PW'($urandom);
            bus_pri     = PW'($urandom);
            usage_pri   = PW'($urandom);
            cur_pri     = PW'($urandom);
            reg_sel     = 2'($urandom);
            wr_en       = ($urandom % 3) == 0;
            wr_data     = $urandom & $urandom;
            step("R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule